// File: doc/BRIEF.md
# 8-bit CPU Control-Transfer Sequencer

This block is the control-transfer engine of a small 8-bit accumulator processor. It executes six instructions: absolute jump, indirect jump, subroutine call, subroutine return, software break and return from interrupt. It talks to a single byte-wide memory bus and makes exactly one bus access, a read or a write, in every clock cycle. The read path is combinational: the byte at `mem_addr` must appear on `mem_rdata` in the same cycle.

The block holds a 16-bit program counter, an 8-bit stack pointer and an 8-bit status register. The stack lives in page one, at address `0x0100 + SP`. A push writes at the current SP and then decrements it. A pull increments SP first and then reads. The status layout is C=bit0, Z=bit1, I=bit2, D=bit3, B=bit4, unused=bit5, V=bit6 and N=bit7.

The sequencer is one state machine. Its states are listed here with the transitions between them:
- FETCH: decodes the opcode and branches to the first state of that instruction, or to HALT.
- ABS_LO → ABS_HI → FETCH.
- IND_PLO → IND_PHI → IND_TLO → IND_THI → FETCH.
- CALL_LO → CALL_STK → CALL_PUSHH → CALL_PUSHL → CALL_HI → FETCH.
- RET_PAD → RET_STK → RET_PLO → RET_PHI → RET_INC → FETCH.
- BRK_PAD → BRK_PUSHH → BRK_PUSHL → BRK_PUSHP → BRK_VLO → BRK_VHI → FETCH.
- RTI_PAD → RTI_STK → RTI_PP → RTI_PLO → RTI_PHI → FETCH.
- HALT: loops on itself until reset.

`instr_done` is high during each FETCH cycle.

Top module: `cfseq_core`

## Requirements
- R1: While reset is held and in the first cycle after it is released, SP is 0xFD and the status register is 0x24. In that first cycle the opcode fetch reads address `boot_pc`, `instr_done` is 1, `bad_op` is 0 and `mem_we` is 0.
- R2: Opcode 0x4C takes 3 cycles and loads PC with its 16-bit operand. The operand's low byte comes first in memory.
- R3: Opcode 0x6C takes 5 cycles. It reads the target's low byte at the pointer address. It reads the high byte at the pointer with only its low byte incremented, so pointer 0x07FF takes its high byte from 0x0700.
- R4: Opcode 0x20 takes 6 cycles. It writes the address of its own last operand byte (opcode address + 2) to the stack, high byte at the starting SP and low byte at SP-1. It leaves SP lowered by 2, jumps to the operand and leaves the status register unchanged.
- R5: Opcode 0x60 takes 6 cycles. It pulls the low byte and then the high byte from the stack, raises SP by 2 and loads PC with the pulled value + 1, modulo 65536. The status register is unchanged.
- R6: Opcode 0x00 takes 7 cycles. It pushes the opcode address + 2 (high byte, then low byte) and then the status with bits 4 and 5 forced to 1. It lowers SP by 3 and sets bit 2 of the status, leaving the other status bits unchanged. It loads PC from 0xFFFE (low byte) and 0xFFFF (high byte).
- R7: Opcode 0x40 takes 6 cycles. It pulls the status, then the PC low byte, then the PC high byte, and raises SP by 3. It does not add 1 to the PC. The restored status has bit 4 cleared and bit 5 set.
- R8: Bus writes go only to page one, and each write cycle lowers SP by exactly one.
- R9: Any other opcode makes `bad_op` go to 1 and stay at 1 until reset. From then on there are no bus writes and no further `instr_done` pulses.
- R10: Status bit 5 reads 1 in every cycle.
- R11: `instr_done` is high for exactly one cycle per instruction, in the cycle that reads the next opcode, and never during a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| boot_pc | input | 16 | PC value loaded on reset |
| mem_addr | output | 16 | Bus address for this cycle |
| mem_we | output | 1 | 1 = write cycle, 0 = read cycle |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid in the same cycle |
| instr_done | output | 1 | High in each opcode fetch cycle |
| bad_op | output | 1 | Sticky flag for an unsupported opcode |
| pc_q | output | 16 | Program counter |
| sp_q | output | 8 | Stack pointer |
| flags_q | output | 8 | Status register |

## Verification
The checker watches bus-level invariants on every cycle:
- writes are confined to page one and each write lowers SP by one;
- SP moves by at most one step per cycle;
- status bit 5 stays set;
- the status does not change in the cycle after a push;
- `bad_op` is sticky, and once it is set there are no writes and no done pulses.

Only the directed scenarios can show the behaviours that depend on what was read from memory. These are:
- the exact cycle count of each instruction;
- the byte order on the stack;
- the return-address + 1 rule, including the wrap from 0xFFFF to 0x0000;
- the indirect-jump page wrap;
- a break followed by a return that restores the pushed state.

// File: rtl/cfseq_pkg.sv
package cfseq_pkg;
    localparam int AW = 16;
    localparam int DW = 8;

    localparam logic [DW-1:0] STACK_PAGE = 8'h01;
    localparam logic [DW-1:0] SP_INIT    = 8'hFD;
    localparam logic [DW-1:0] FL_INIT    = 8'h24;
    localparam logic [AW-1:0] BRK_VEC    = 16'hFFFE;

    localparam int FL_I = 2;
    localparam int FL_B = 4;
    localparam int FL_U = 5;

    localparam logic [DW-1:0] OP_BRK  = 8'h00;
    localparam logic [DW-1:0] OP_CALL = 8'h20;
    localparam logic [DW-1:0] OP_RTI  = 8'h40;
    localparam logic [DW-1:0] OP_JABS = 8'h4C;
    localparam logic [DW-1:0] OP_RET  = 8'h60;
    localparam logic [DW-1:0] OP_JIND = 8'h6C;

    typedef enum logic [4:0] {
        ST_FETCH,
        ST_ABS_LO, ST_ABS_HI,
        ST_IND_PLO, ST_IND_PHI, ST_IND_TLO, ST_IND_THI,
        ST_CALL_LO, ST_CALL_STK, ST_CALL_PUSHH, ST_CALL_PUSHL, ST_CALL_HI,
        ST_RET_PAD, ST_RET_STK, ST_RET_PLO, ST_RET_PHI, ST_RET_INC,
        ST_BRK_PAD, ST_BRK_PUSHH, ST_BRK_PUSHL, ST_BRK_PUSHP, ST_BRK_VLO, ST_BRK_VHI,
        ST_RTI_PAD, ST_RTI_STK, ST_RTI_PP, ST_RTI_PLO, ST_RTI_PHI,
        ST_HALT
    } seq_state_e;

    typedef enum logic [1:0] { PC_HOLD, PC_INC, PC_LOAD } pc_cmd_e;
    typedef enum logic [1:0] { SP_HOLD, SP_INC, SP_DEC } sp_cmd_e;
    typedef enum logic [1:0] { FL_HOLD, FL_SETI, FL_LOAD } fl_cmd_e;
endpackage

// File: rtl/cfseq_decode.sv
module cfseq_decode
    import cfseq_pkg::*;
(
    input  logic [DW-1:0] opcode,
    output seq_state_e    entry_state,
    output logic          legal
);
    always_comb begin
        legal       = 1'b1;
        entry_state = ST_HALT;
        unique case (opcode)
            OP_JABS: entry_state = ST_ABS_LO;
            OP_JIND: entry_state = ST_IND_PLO;
            OP_CALL: entry_state = ST_CALL_LO;
            OP_RET:  entry_state = ST_RET_PAD;
            OP_BRK:  entry_state = ST_BRK_PAD;
            OP_RTI:  entry_state = ST_RTI_PAD;
            default: begin
                legal       = 1'b0;
                entry_state = ST_HALT;
            end
        endcase
    end
endmodule

// File: rtl/cfseq_regs.sv
module cfseq_regs
    import cfseq_pkg::*;
#(
    parameter logic [DW-1:0] SP_RESET = SP_INIT,
    parameter logic [DW-1:0] FL_RESET = FL_INIT
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] boot_pc,
    input  pc_cmd_e       pc_cmd,
    input  logic [AW-1:0] pc_val,
    input  sp_cmd_e       sp_cmd,
    input  fl_cmd_e       fl_cmd,
    input  logic [DW-1:0] fl_val,
    input  logic          tmp_lo_we,
    input  logic          tmp_hi_we,
    input  logic [DW-1:0] tmp_din,
    output logic [AW-1:0] pc_q,
    output logic [DW-1:0] sp_q,
    output logic [DW-1:0] fl_q,
    output logic [AW-1:0] tmp_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc_q <= boot_pc;
        end else begin
            unique case (pc_cmd)
                PC_INC:  pc_q <= pc_q + 1'b1;
                PC_LOAD: pc_q <= pc_val;
                default: pc_q <= pc_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sp_q <= SP_RESET;
        end else begin
            unique case (sp_cmd)
                SP_INC:  sp_q <= sp_q + 1'b1;
                SP_DEC:  sp_q <= sp_q - 1'b1;
                default: sp_q <= sp_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fl_q <= FL_RESET;
        end else begin
            unique case (fl_cmd)
                FL_SETI: fl_q <= fl_q | (DW'(1) << FL_I);
                FL_LOAD: fl_q <= fl_val;
                default: fl_q <= fl_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmp_q <= '0;
        end else begin
            if (tmp_lo_we) tmp_q[DW-1:0]  <= tmp_din;
            if (tmp_hi_we) tmp_q[AW-1:DW] <= tmp_din;
        end
    end
endmodule

// File: rtl/cfseq_core.sv
module cfseq_core
    import cfseq_pkg::*;
#(
    parameter logic [DW-1:0] SP_RESET   = SP_INIT,
    parameter logic [DW-1:0] FL_RESET   = FL_INIT,
    parameter logic [AW-1:0] VEC_ADDR   = BRK_VEC,
    parameter logic [DW-1:0] STACK_PG   = STACK_PAGE
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [15:0]   boot_pc,
    output logic [15:0]   mem_addr,
    output logic          mem_we,
    output logic [7:0]    mem_wdata,
    input  logic [7:0]    mem_rdata,
    output logic          instr_done,
    output logic          bad_op,
    output logic [15:0]   pc_q,
    output logic [7:0]    sp_q,
    output logic [7:0]    flags_q
);
    localparam logic [DW-1:0] B_MASK = DW'(1) << FL_B;
    localparam logic [DW-1:0] U_MASK = DW'(1) << FL_U;

    seq_state_e    state_q, state_d;
    seq_state_e    entry_state;
    logic          op_legal;

    pc_cmd_e       pc_cmd;
    logic [AW-1:0] pc_val;
    sp_cmd_e       sp_cmd;
    fl_cmd_e       fl_cmd;
    logic [DW-1:0] fl_val;
    logic          tmp_lo_we, tmp_hi_we;
    logic [AW-1:0] tmp_q;
    logic [AW-1:0] stk_addr;

    cfseq_decode u_dec (
        .opcode      (mem_rdata),
        .entry_state (entry_state),
        .legal       (op_legal)
    );

    cfseq_regs #(
        .SP_RESET (SP_RESET),
        .FL_RESET (FL_RESET)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .boot_pc   (boot_pc),
        .pc_cmd    (pc_cmd),
        .pc_val    (pc_val),
        .sp_cmd    (sp_cmd),
        .fl_cmd    (fl_cmd),
        .fl_val    (fl_val),
        .tmp_lo_we (tmp_lo_we),
        .tmp_hi_we (tmp_hi_we),
        .tmp_din   (mem_rdata),
        .pc_q      (pc_q),
        .sp_q      (sp_q),
        .fl_q      (flags_q),
        .tmp_q     (tmp_q)
    );

    assign stk_addr = {STACK_PG, sp_q};
    assign bad_op   = (state_q == ST_HALT);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_FETCH;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_FETCH:      state_d = op_legal ? entry_state : ST_HALT;
            ST_ABS_LO:     state_d = ST_ABS_HI;
            ST_ABS_HI:     state_d = ST_FETCH;
            ST_IND_PLO:    state_d = ST_IND_PHI;
            ST_IND_PHI:    state_d = ST_IND_TLO;
            ST_IND_TLO:    state_d = ST_IND_THI;
            ST_IND_THI:    state_d = ST_FETCH;
            ST_CALL_LO:    state_d = ST_CALL_STK;
            ST_CALL_STK:   state_d = ST_CALL_PUSHH;
            ST_CALL_PUSHH: state_d = ST_CALL_PUSHL;
            ST_CALL_PUSHL: state_d = ST_CALL_HI;
            ST_CALL_HI:    state_d = ST_FETCH;
            ST_RET_PAD:    state_d = ST_RET_STK;
            ST_RET_STK:    state_d = ST_RET_PLO;
            ST_RET_PLO:    state_d = ST_RET_PHI;
            ST_RET_PHI:    state_d = ST_RET_INC;
            ST_RET_INC:    state_d = ST_FETCH;
            ST_BRK_PAD:    state_d = ST_BRK_PUSHH;
            ST_BRK_PUSHH:  state_d = ST_BRK_PUSHL;
            ST_BRK_PUSHL:  state_d = ST_BRK_PUSHP;
            ST_BRK_PUSHP:  state_d = ST_BRK_VLO;
            ST_BRK_VLO:    state_d = ST_BRK_VHI;
            ST_BRK_VHI:    state_d = ST_FETCH;
            ST_RTI_PAD:    state_d = ST_RTI_STK;
            ST_RTI_STK:    state_d = ST_RTI_PP;
            ST_RTI_PP:     state_d = ST_RTI_PLO;
            ST_RTI_PLO:    state_d = ST_RTI_PHI;
            ST_RTI_PHI:    state_d = ST_FETCH;
            ST_HALT:       state_d = ST_HALT;
            default:       state_d = ST_HALT;
        endcase
    end

    // Output / datapath control
    always_comb begin
        mem_addr   = pc_q;
        mem_we     = 1'b0;
        mem_wdata  = '0;
        instr_done = 1'b0;
        pc_cmd     = PC_HOLD;
        pc_val     = pc_q;
        sp_cmd     = SP_HOLD;
        fl_cmd     = FL_HOLD;
        fl_val     = flags_q;
        tmp_lo_we  = 1'b0;
        tmp_hi_we  = 1'b0;
        unique case (state_q)
            ST_FETCH: begin
                instr_done = 1'b1;
                if (op_legal) pc_cmd = PC_INC;
            end
            ST_ABS_LO: begin
                tmp_lo_we = 1'b1;
                pc_cmd    = PC_INC;
            end
            ST_ABS_HI: begin
                pc_cmd = PC_LOAD;
                pc_val = {mem_rdata, tmp_q[DW-1:0]};
            end
            ST_IND_PLO: begin
                tmp_lo_we = 1'b1;
                pc_cmd    = PC_INC;
            end
            ST_IND_PHI: begin
                tmp_hi_we = 1'b1;
                pc_cmd    = PC_INC;
            end
            ST_IND_TLO: begin
                mem_addr = tmp_q;
                pc_cmd   = PC_LOAD;
                pc_val   = {pc_q[AW-1:DW], mem_rdata};
            end
            ST_IND_THI: begin
                // high byte from the same page: only the low byte steps
                mem_addr = {tmp_q[AW-1:DW], tmp_q[DW-1:0] + 1'b1};
                pc_cmd   = PC_LOAD;
                pc_val   = {mem_rdata, pc_q[DW-1:0]};
            end
            ST_CALL_LO: begin
                tmp_lo_we = 1'b1;
                pc_cmd    = PC_INC;
            end
            ST_CALL_STK: begin
                mem_addr = stk_addr;
            end
            ST_CALL_PUSHH, ST_BRK_PUSHH: begin
                mem_addr  = stk_addr;
                mem_we    = 1'b1;
                mem_wdata = pc_q[AW-1:DW];
                sp_cmd    = SP_DEC;
            end
            ST_CALL_PUSHL, ST_BRK_PUSHL: begin
                mem_addr  = stk_addr;
                mem_we    = 1'b1;
                mem_wdata = pc_q[DW-1:0];
                sp_cmd    = SP_DEC;
            end
            ST_CALL_HI: begin
                pc_cmd = PC_LOAD;
                pc_val = {mem_rdata, tmp_q[DW-1:0]};
            end
            ST_RET_PAD, ST_RTI_PAD: begin
                mem_addr = pc_q;
            end
            ST_RET_STK, ST_RTI_STK: begin
                mem_addr = stk_addr;
                sp_cmd   = SP_INC;
            end
            ST_RET_PLO, ST_RTI_PLO: begin
                mem_addr  = stk_addr;
                tmp_lo_we = 1'b1;
                sp_cmd    = SP_INC;
            end
            ST_RET_PHI, ST_RTI_PHI: begin
                mem_addr = stk_addr;
                pc_cmd   = PC_LOAD;
                pc_val   = {mem_rdata, tmp_q[DW-1:0]};
            end
            ST_RET_INC: begin
                pc_cmd = PC_INC;
            end
            ST_BRK_PAD: begin
                pc_cmd = PC_INC;
            end
            ST_BRK_PUSHP: begin
                mem_addr  = stk_addr;
                mem_we    = 1'b1;
                mem_wdata = flags_q | B_MASK | U_MASK;
                sp_cmd    = SP_DEC;
            end
            ST_BRK_VLO: begin
                mem_addr  = VEC_ADDR;
                tmp_lo_we = 1'b1;
                fl_cmd    = FL_SETI;
            end
            ST_BRK_VHI: begin
                mem_addr = VEC_ADDR + 1'b1;
                pc_cmd   = PC_LOAD;
                pc_val   = {mem_rdata, tmp_q[DW-1:0]};
            end
            ST_RTI_PP: begin
                mem_addr = stk_addr;
                fl_cmd   = FL_LOAD;
                fl_val   = (mem_rdata & ~B_MASK) | U_MASK;
                sp_cmd   = SP_INC;
            end
            ST_HALT: begin
                mem_addr = pc_q;
            end
            default: begin
                mem_addr = pc_q;
            end
        endcase
    end
endmodule

// File: rtl/cfseq_checker.sv
module cfseq_checker (
    input logic        clk,
    input logic        rst_n,
    input logic [15:0] mem_addr,
    input logic        mem_we,
    input logic        instr_done,
    input logic        bad_op,
    input logic [7:0]  sp_q,
    input logic [7:0]  flags_q
);
    assert_write_page_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (mem_addr[15:8] == 8'h01));

    assert_write_dec_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> (sp_q == $past(sp_q) - 8'd1));

    assert_sp_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (sp_q == $past(sp_q) || sp_q == $past(sp_q) + 8'd1 ||
                  sp_q == $past(sp_q) - 8'd1));

    assert_unused_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
        flags_q[5]);

    assert_push_keeps_flags_R6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> $stable(flags_q));

    assert_bad_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        bad_op |=> bad_op);

    assert_bad_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        bad_op |-> (!mem_we && !instr_done));

    assert_done_reads_R11: assert property (@(posedge clk) disable iff (!rst_n)
        instr_done |-> !mem_we);
endmodule

bind cfseq_core cfseq_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mem_addr   (mem_addr),
    .mem_we     (mem_we),
    .instr_done (instr_done),
    .bad_op     (bad_op),
    .sp_q       (sp_q),
    .flags_q    (flags_q)
);

// File: tb/sim_cfseq_core.sv
`timescale 1ns/100ps
module sim_cfseq_core;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] boot_pc = 16'h0400;
    logic [15:0] mem_addr;
    logic        mem_we;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata;
    logic        instr_done;
    logic        bad_op;
    logic [15:0] pc_q;
    logic [7:0]  sp_q;
    logic [7:0]  flags_q;

    int n_checks = 0;
    int n_fail   = 0;
    int n_writes = 0;

    // 4 KiB aliased memory; test addresses are chosen not to collide
    logic [7:0] mem [0:4095];

    always #2.5 clk = ~clk;

    assign mem_rdata = mem[mem_addr[11:0]];

    always @(posedge clk) begin
        if (rst_n && mem_we) mem[mem_addr[11:0]] <= mem_wdata;
    end

    always @(negedge clk) begin
        if (rst_n && mem_we) n_writes++;
    end

    cfseq_core u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .boot_pc    (boot_pc),
        .mem_addr   (mem_addr),
        .mem_we     (mem_we),
        .mem_wdata  (mem_wdata),
        .mem_rdata  (mem_rdata),
        .instr_done (instr_done),
        .bad_op     (bad_op),
        .pc_q       (pc_q),
        .sp_q       (sp_q),
        .flags_q    (flags_q)
    );

    initial begin
        #200000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: run did not finish (actual hang, expected completion)");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic clear_mem();
        for (int i = 0; i < 4096; i++) mem[i] = 8'hFF;
    endtask

    // reset and leave the bench at the negedge of the first fetch cycle
    task automatic do_reset(input logic [15:0] pc);
        rst_n   = 1'b0;
        boot_pc = pc;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #0.5;
    endtask

    // count cycles until the next fetch cycle
    task automatic run_instr(output int cyc);
        cyc = 0;
        do begin
            @(negedge clk);
            cyc++;
        end while (!instr_done && cyc < 20);
        #0.5;
    endtask

    task automatic t_reset();
        clear_mem();
        mem[12'h400] = 8'h4C;
        do_reset(16'h0400);
        chk("R1 sp", 16'(sp_q), 16'h00FD);
        chk("R1 flags", 16'(flags_q), 16'h0024);
        chk("R1 fetch addr", mem_addr, 16'h0400);
        chk("R1 done", 16'(instr_done), 16'd1);
        chk("R1 bad_op", 16'(bad_op), 16'd0);
        chk("R1 we", 16'(mem_we), 16'd0);
    endtask

    task automatic t_jabs();
        int cyc;
        clear_mem();
        mem[12'h400] = 8'h4C; mem[12'h401] = 8'h34; mem[12'h402] = 8'h12;
        do_reset(16'h0400);
        run_instr(cyc);
        chk("R2 cycles", 16'(cyc), 16'd3);
        chk("R2 pc", pc_q, 16'h1234);
        chk("R11 done at fetch", mem_addr, 16'h1234);
    endtask

    task automatic t_jind();
        int cyc;
        clear_mem();
        mem[12'h400] = 8'h6C; mem[12'h401] = 8'hFF; mem[12'h402] = 8'h07;
        mem[12'h7FF] = 8'h80; mem[12'h700] = 8'h50; mem[12'h800] = 8'hAA;
        do_reset(16'h0400);
        run_instr(cyc);
        chk("R3 cycles wrap", 16'(cyc), 16'd5);
        chk("R3 pc wrap", pc_q, 16'h5080);
        clear_mem();
        mem[12'h400] = 8'h6C; mem[12'h401] = 8'h20; mem[12'h402] = 8'h07;
        mem[12'h720] = 8'h78; mem[12'h721] = 8'h06;
        do_reset(16'h0400);
        run_instr(cyc);
        chk("R3 pc plain", pc_q, 16'h0678);
    endtask

    task automatic t_call_ret();
        int cyc;
        int w0;
        clear_mem();
        mem[12'h400] = 8'h20; mem[12'h401] = 8'h00; mem[12'h402] = 8'h06;
        mem[12'h600] = 8'h60;
        do_reset(16'h0400);
        w0 = n_writes;
        run_instr(cyc);
        chk("R4 cycles", 16'(cyc), 16'd6);
        chk("R4 pc", pc_q, 16'h0600);
        chk("R4 sp", 16'(sp_q), 16'h00FB);
        chk("R4 hi byte", 16'(mem[12'h1FD]), 16'h0004);
        chk("R4 lo byte", 16'(mem[12'h1FC]), 16'h0002);
        chk("R4 flags", 16'(flags_q), 16'h0024);
        chk("R8 write count call", 16'(n_writes - w0), 16'd2);
        run_instr(cyc);
        chk("R5 cycles", 16'(cyc), 16'd6);
        chk("R5 pc", pc_q, 16'h0403);
        chk("R5 sp", 16'(sp_q), 16'h00FD);
        chk("R5 flags", 16'(flags_q), 16'h0024);
    endtask

    task automatic t_ret_wrap();
        int cyc;
        clear_mem();
        mem[12'h400] = 8'h60; mem[12'h1FE] = 8'hFF; mem[12'h1FF] = 8'hFF;
        do_reset(16'h0400);
        run_instr(cyc);
        chk("R5 wrap pc", pc_q, 16'h0000);
        chk("R5 wrap sp", 16'(sp_q), 16'h00FF);
    endtask

    task automatic t_brk_rti();
        int cyc;
        int w0;
        clear_mem();
        // RTI first, to load a rich status; SP wraps through 0xFF to 0x00
        mem[12'h400] = 8'h40;
        mem[12'h1FE] = 8'hD9; mem[12'h1FF] = 8'h00; mem[12'h100] = 8'h05;
        mem[12'h500] = 8'h00;
        mem[12'hFFE] = 8'h34; mem[12'hFFF] = 8'h06;
        mem[12'h634] = 8'h40;
        do_reset(16'h0400);
        run_instr(cyc);
        chk("R7 cycles", 16'(cyc), 16'd6);
        chk("R7 pc no +1", pc_q, 16'h0500);
        chk("R7 sp", 16'(sp_q), 16'h0000);
        chk("R7 flags B clear U set", 16'(flags_q), 16'h00E9);
        w0 = n_writes;
        run_instr(cyc);
        chk("R6 cycles", 16'(cyc), 16'd7);
        chk("R6 pc vector", pc_q, 16'h0634);
        chk("R6 sp", 16'(sp_q), 16'h00FD);
        chk("R6 pushed hi", 16'(mem[12'h100]), 16'h0005);
        chk("R6 pushed lo", 16'(mem[12'h1FF]), 16'h0002);
        chk("R6 pushed status", 16'(mem[12'h1FE]), 16'h00F9);
        chk("R6 flags only I set", 16'(flags_q), 16'h00ED);
        chk("R8 write count brk", 16'(n_writes - w0), 16'd3);
        run_instr(cyc);
        chk("R7 after brk cycles", 16'(cyc), 16'd6);
        chk("R7 after brk pc", pc_q, 16'h0502);
        chk("R7 after brk flags", 16'(flags_q), 16'h00E9);
        chk("R7 after brk sp", 16'(sp_q), 16'h0000);
    endtask

    task automatic t_illegal();
        int w0;
        int dones;
        clear_mem();
        mem[12'h400] = 8'h02;
        do_reset(16'h0400);
        w0 = n_writes;
        dones = 0;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (instr_done) dones++;
        end
        chk("R9 bad_op", 16'(bad_op), 16'd1);
        chk("R9 no done", 16'(dones), 16'd0);
        chk("R9 no writes", 16'(n_writes - w0), 16'd0);
        mem[12'h400] = 8'h4C;
        do_reset(16'h0400);
        chk("R9 cleared by reset", 16'(bad_op), 16'd0);
    endtask

    initial begin
        t_reset();
        t_jabs();
        t_jind();
        t_call_ret();
        t_ret_wrap();
        t_brk_rti();
        t_illegal();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule